// File: doc/BRIEF.md
# Shared Multiply and Shift Unit

This execute-stage unit performs 32-bit multiplies and all three shift kinds on a single hardware multiplier array. A shift by `n` is carried out by multiplying the operand by a power of two derived from `n`. The right half or the left half of the double-width product is then taken as the shifted value. Because of this, shift support costs only a one-hot power-of-two decoder and a word select around the multiplier, with no separate barrel shifter.

An operation is issued with a one-cycle start strobe. The unit raises `busy_o` for exactly one cycle, which the pipeline uses as its stall for the extra cycle. In the cycle after that, the result is in place. Shift results appear on `result_o`, which is bound for the register-file write port. Multiply results land in a dedicated HI/LO register pair, which the move-from-HI and move-from-LO instructions read through `hi_o` and `lo_o`.

Top module: `mulshift_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `busy_o`, `result_o`, `hi_o` and `lo_o` are all zero.
- R2: Operation codes on `op_i` are 3'b000 shift left logical, 3'b001 shift right logical, 3'b010 shift right arithmetic, 3'b100 signed multiply and 3'b101 unsigned multiply. When `start_i` is sampled high with a valid code while `busy_o` is low, `busy_o` is high in the following cycle only.
- R3: Outputs update at the second rising edge after issue, which is the edge ending the busy cycle. The new values are therefore visible in the cycle in which `busy_o` has returned low.
- R4: A left logical shift gives `a_i` shifted left by `shamt_i` (0..31), with zeros filled in.
- R5: A right logical shift gives `a_i` shifted right by `shamt_i` with zeros filled in. A shift amount of 0 returns `a_i` unchanged.
- R6: A right arithmetic shift gives `a_i` shifted right by `shamt_i` with copies of bit 31 filled in. A shift amount of 0 returns `a_i` unchanged.
- R7: A signed multiply treats `a_i` and `b_i` as two's complement and places bits 63:32 of the 64-bit product in HI (`hi_o`) and bits 31:0 in LO (`lo_o`).
- R8: An unsigned multiply treats both operands as unsigned and splits the 64-bit product the same way as R7.
- R9: A multiply leaves `result_o` unchanged, and a shift leaves `hi_o` and `lo_o` unchanged. No output changes except at the edge named in R3.
- R10: A start strobe is ignored when `busy_o` is high or when the code is 3'b011, 3'b110 or 3'b111. An ignored strobe does not raise `busy_o` and changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Issue strobe for one operation |
| op_i | input | 3 | Operation code (see R2) |
| a_i | input | 32 | Operand to be shifted, or multiplicand |
| b_i | input | 32 | Multiplier operand (multiplies only) |
| shamt_i | input | 5 | Shift amount (shifts only) |
| result_o | output | 32 | Shift result for the register-file write port |
| hi_o | output | 32 | HI register, upper product word |
| lo_o | output | 32 | LO register, lower product word |
| busy_o | output | 1 | Stall request, high during the extra cycle |

## Verification
Two functions can meet in the one busy cycle: the completion of an accepted operation and a second start strobe that the pipeline presents before honouring the stall. The bench provokes this by holding `start_i` high across the busy cycle while switching the operation code to a multiply. It then judges that `busy_o` falls on schedule, that `result_o` carries the first shift, and that HI/LO are untouched by the second request. A multiply issued directly after a shift, and the reverse, also checks that each kind of result leaves the other kind's register alone.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

   typedef enum logic [2:0] {
      OP_SLL   = 3'b000,
      OP_SRL   = 3'b001,
      OP_SRA   = 3'b010,
      OP_MULT  = 3'b100,
      OP_MULTU = 3'b101
   } ms_op_e;

   function automatic logic op_is_shift(input logic [2:0] code);
      return (code == OP_SLL) || (code == OP_SRL) || (code == OP_SRA);
   endfunction

   function automatic logic op_is_mul(input logic [2:0] code);
      return (code == OP_MULT) || (code == OP_MULTU);
   endfunction

   function automatic logic op_is_valid(input logic [2:0] code);
      return op_is_shift(code) || op_is_mul(code);
   endfunction

endpackage

// File: rtl/ms_operand_prep.sv
// Forms the two (W+1)-bit signed multiplier operands for every operation.
// Shifts replace the second operand with a one-hot power of two.
module ms_operand_prep
   import mulshift_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [2:0]                 op,
   input  logic [DATA_W-1:0]          a,
   input  logic [DATA_W-1:0]          b,
   input  logic [$clog2(DATA_W)-1:0]  shamt,
   output logic [DATA_W:0]            x,
   output logic [DATA_W:0]            y,
   output logic                       sel_hi
);
   localparam int SH_W = $clog2(DATA_W);
   localparam int K_W  = SH_W + 1;

   logic [K_W-1:0]    pow_idx;
   logic [DATA_W:0]   pow;
   logic [DATA_W:0]   mul_y;
   logic              amt_zero;

   assign amt_zero = (shamt == '0);

   // exponent: n for left shift, W-n for right shifts (0 when n is 0)
   always_comb begin
      if (op == OP_SLL || amt_zero)
         pow_idx = {1'b0, shamt};
      else
         pow_idx = K_W'(DATA_W) - {1'b0, shamt};
   end

   // one-hot power-of-two decoder
   genvar j;
   generate
      for (j = 0; j <= DATA_W; j++) begin : g_pow
         assign pow[j] = (pow_idx == K_W'(j));
      end
   endgenerate

   always_comb begin
      x      = '0;
      mul_y  = '0;
      sel_hi = 1'b0;
      unique case (op)
         OP_SLL: begin
            x = {1'b0, a};
         end
         OP_SRL: begin
            x      = {1'b0, a};
            sel_hi = !amt_zero;
         end
         OP_SRA: begin
            x      = {a[DATA_W-1], a};
            sel_hi = !amt_zero;
         end
         OP_MULT: begin
            x     = {a[DATA_W-1], a};
            mul_y = {b[DATA_W-1], b};
         end
         OP_MULTU: begin
            x     = {1'b0, a};
            mul_y = {1'b0, b};
         end
         default: begin
            x = '0;
         end
      endcase
   end

   assign y = op_is_shift(op) ? pow : mul_y;

endmodule

// File: rtl/ms_multiplier.sv
// Signed (W+1)x(W+1) multiplier with a (2W+2)-bit product.
// IMPL 0 infers the operator; IMPL 1 builds explicit partial-product rows.
module ms_multiplier #(
   parameter int DATA_W = 32,
   parameter int IMPL   = 0
) (
   input  logic [DATA_W:0]       x,
   input  logic [DATA_W:0]       y,
   output logic [2*DATA_W+1:0]   p
);
   localparam int OP_W = DATA_W + 1;
   localparam int P_W  = 2 * OP_W;

   logic [P_W-1:0] xs;
   logic [P_W-1:0] ys;

   assign xs = {{OP_W{x[DATA_W]}}, x};
   assign ys = {{OP_W{y[DATA_W]}}, y};

   generate
      if (IMPL == 0) begin : g_infer
         assign p = xs * ys;
      end else begin : g_rows
         logic [P_W-1:0] row [OP_W];
         genvar i;
         for (i = 0; i < OP_W; i++) begin : g_row
            assign row[i] = y[i] ? (xs << i) : '0;
         end
         always_comb begin
            p = '0;
            for (int r = 0; r < DATA_W; r++) begin
               p = p + row[r];
            end
            // top bit of a two's complement multiplier has negative weight
            p = p - row[DATA_W];
         end
      end
   endgenerate

endmodule

// File: rtl/ms_result_sel.sv
// Slices the double-width product into the register-file word and HI/LO.
module ms_result_sel #(
   parameter int DATA_W = 32
) (
   input  logic [2*DATA_W+1:0]  p,
   input  logic                 sel_hi,
   output logic [DATA_W-1:0]    shift_word,
   output logic [DATA_W-1:0]    hi_word,
   output logic [DATA_W-1:0]    lo_word
);
   assign hi_word    = p[2*DATA_W-1:DATA_W];
   assign lo_word    = p[DATA_W-1:0];
   assign shift_word = sel_hi ? hi_word : lo_word;
endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit
   import mulshift_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MULT_IMPL = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [2:0]                 op_i,
   input  logic [DATA_W-1:0]          a_i,
   input  logic [DATA_W-1:0]          b_i,
   input  logic [$clog2(DATA_W)-1:0]  shamt_i,
   output logic [DATA_W-1:0]          result_o,
   output logic [DATA_W-1:0]          hi_o,
   output logic [DATA_W-1:0]          lo_o,
   output logic                       busy_o
);
   localparam int P_W = 2 * DATA_W + 2;

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("mulshift_unit: DATA_W must be a power of two of at least 8");
      end
      if (MULT_IMPL != 0 && MULT_IMPL != 1) begin : g_bad_impl
         $error("mulshift_unit: MULT_IMPL must be 0 or 1");
      end
   endgenerate

   logic              accept;
   logic [DATA_W:0]   x_d, y_d;
   logic              sel_hi_d;

   logic              busy_q;
   logic [2:0]        op_q;
   logic [DATA_W:0]   x_q, y_q;
   logic              sel_hi_q;

   logic [P_W-1:0]    prod;
   logic [DATA_W-1:0] shift_word, hi_word, lo_word;

   logic [DATA_W-1:0] result_q, hi_q, lo_q;

   assign accept = start_i && !busy_q && op_is_valid(op_i);

   ms_operand_prep #(.DATA_W(DATA_W)) u_prep (
      .op     (op_i),
      .a      (a_i),
      .b      (b_i),
      .shamt  (shamt_i),
      .x      (x_d),
      .y      (y_d),
      .sel_hi (sel_hi_d)
   );

   ms_multiplier #(.DATA_W(DATA_W), .IMPL(MULT_IMPL)) u_mul (
      .x (x_q),
      .y (y_q),
      .p (prod)
   );

   ms_result_sel #(.DATA_W(DATA_W)) u_sel (
      .p          (prod),
      .sel_hi     (sel_hi_q),
      .shift_word (shift_word),
      .hi_word    (hi_word),
      .lo_word    (lo_word)
   );

   // issue stage: capture prepared operands
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         op_q     <= '0;
         x_q      <= '0;
         y_q      <= '0;
         sel_hi_q <= 1'b0;
      end else begin
         busy_q <= accept;
         if (accept) begin
            op_q     <= op_i;
            x_q      <= x_d;
            y_q      <= y_d;
            sel_hi_q <= sel_hi_d;
         end
      end
   end

   // completion stage: write the destination selected by the operation
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_q <= '0;
         hi_q     <= '0;
         lo_q     <= '0;
      end else if (busy_q) begin
         if (op_is_shift(op_q)) begin
            result_q <= shift_word;
         end
         if (op_is_mul(op_q)) begin
            hi_q <= hi_word;
            lo_q <= lo_word;
         end
      end
   end

   assign result_o = result_q;
   assign hi_o     = hi_q;
   assign lo_o     = lo_q;
   assign busy_o   = busy_q;

endmodule

// File: rtl/mulshift_checker.sv
module mulshift_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        op_i,
   input logic [DATA_W-1:0] result_o,
   input logic [DATA_W-1:0] hi_o,
   input logic [DATA_W-1:0] lo_o,
   input logic              busy_o
);
   logic valid_code;
   assign valid_code = (op_i == 3'b000) || (op_i == 3'b001) || (op_i == 3'b010)
                    || (op_i == 3'b100) || (op_i == 3'b101);

   // R2: an accepted start gives a busy cycle next
   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && valid_code) |=> busy_o);

   // R2 / R10: busy never lasts two cycles, even with a strobe during busy
   assert_busy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !busy_o);

   // R10: unused codes never start an operation
   assert_bad_code_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_code && !busy_o) |=> !busy_o);

   // R3 / R9: HI and LO only change at the edge ending a busy cycle
   assert_hilo_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> ($stable(hi_o) && $stable(lo_o)));

   // R3 / R9: the shift result only changes at the edge ending a busy cycle
   assert_result_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(result_o));

   // R1: outputs cleared by reset
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (!busy_o && result_o == '0 && hi_o == '0 && lo_o == '0));

endmodule

bind mulshift_unit mulshift_checker #(.DATA_W(DATA_W)) u_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .op_i     (op_i),
   .result_o (result_o),
   .hi_o     (hi_o),
   .lo_o     (lo_o),
   .busy_o   (busy_o)
);

// File: tb/mulshift_unit_tb.sv
module mulshift_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic [4:0]  shamt_i = '0;
   logic [31:0] result_o, hi_o, lo_o;
   logic        busy_o;

   int n_checks = 0;
   int n_fails  = 0;

   // bench model of the architectural outputs
   logic [31:0] m_res = '0;
   logic [31:0] m_hi  = '0;
   logic [31:0] m_lo  = '0;

   always #10 clk = ~clk;

   mulshift_unit u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .a_i      (a_i),
      .b_i      (b_i),
      .shamt_i  (shamt_i),
      .result_o (result_o),
      .hi_o     (hi_o),
      .lo_o     (lo_o),
      .busy_o   (busy_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [2:0] op, input logic [31:0] a,
                                 input logic [31:0] b, input logic [4:0] n);
      logic [63:0] p;
      case (op)
         3'b000: m_res = a << n;
         3'b001: m_res = a >> n;
         3'b010: m_res = $signed(a) >>> n;
         3'b100: begin
            p = 64'($signed(a)) * 64'($signed(b));
            m_hi = p[63:32]; m_lo = p[31:0];
         end
         3'b101: begin
            p = {32'b0, a} * {32'b0, b};
            m_hi = p[63:32]; m_lo = p[31:0];
         end
         default: ;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'b000:  return "R4";
         3'b001:  return "R5";
         3'b010:  return "R6";
         3'b100:  return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check_outputs(input string req);
      chk({req, " result"}, result_o, m_res);
      chk({req, " hi"}, hi_o, m_hi);
      chk({req, " lo"}, lo_o, m_lo);
   endtask

   // issue one operation at a falling edge and check it through completion
   task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] n);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b; shamt_i = n;
      @(negedge clk);
      start_i = 1'b0;
      a_i = $urandom; b_i = $urandom; shamt_i = 5'($urandom);
      chk("R2 busy after issue", 32'(busy_o), 32'd1);
      // R9: nothing visible moves during the busy cycle
      check_outputs("R9 during busy");
      @(negedge clk);
      model(op, a, b, n);
      chk("R3 busy low at completion", 32'(busy_o), 32'd0);
      check_outputs(req_of(op));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic [31:0] seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy in reset", 32'(busy_o), 32'd0);
      check_outputs("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", 32'(busy_o), 32'd0);
      check_outputs("R1 after reset");

      // directed shift corners
      run_op(3'b000, 32'h8000_0001, 32'h0, 5'd0);    // R4 n=0
      run_op(3'b000, 32'h8000_0001, 32'h0, 5'd31);   // R4 n=31
      run_op(3'b000, 32'hdead_beef, 32'h0, 5'd4);    // R4
      run_op(3'b001, 32'h8000_0000, 32'h0, 5'd0);    // R5 pass-through
      run_op(3'b001, 32'h8000_0000, 32'h0, 5'd31);   // R5 n=31
      run_op(3'b001, 32'hffff_ffff, 32'h0, 5'd1);    // R5 zero fill
      run_op(3'b010, 32'h8000_0000, 32'h0, 5'd31);   // R6 -> all ones
      run_op(3'b010, 32'h8000_0000, 32'h0, 5'd0);    // R6 pass-through
      run_op(3'b010, 32'h7fff_ffff, 32'h0, 5'd30);   // R6 positive
      // directed multiply corners
      run_op(3'b100, 32'hffff_ffff, 32'hffff_ffff, 5'd0); // R7 -1*-1
      run_op(3'b100, 32'h8000_0000, 32'h8000_0000, 5'd0); // R7 min*min
      run_op(3'b100, 32'hffff_ffff, 32'h0000_0001, 5'd0); // R7 -1*1
      run_op(3'b101, 32'hffff_ffff, 32'hffff_ffff, 5'd0); // R8 max*max
      run_op(3'b101, 32'h8000_0000, 32'h0000_0002, 5'd0); // R8

      // R10: unused codes are ignored
      for (int c = 0; c < 3; c++) begin
         start_i = 1'b1;
         op_i = (c == 0) ? 3'b011 : ((c == 1) ? 3'b110 : 3'b111);
         a_i = 32'h1234_5678; b_i = 32'h9abc_def0; shamt_i = 5'd3;
         @(negedge clk);
         start_i = 1'b0;
         chk("R10 bad code no busy", 32'(busy_o), 32'd0);
         @(negedge clk);
         check_outputs("R10 bad code");
      end

      // R10: strobe held through the busy cycle with a multiply request
      start_i = 1'b1; op_i = 3'b000; a_i = 32'h0000_0003; shamt_i = 5'd1;
      @(negedge clk);
      chk("R10 first accepted", 32'(busy_o), 32'd1);
      op_i = 3'b100; a_i = 32'h7fff_ffff; b_i = 32'h7fff_ffff;
      @(negedge clk);
      start_i = 1'b0;
      model(3'b000, 32'h0000_0003, 32'h0, 5'd1);
      chk("R10 second strobe ignored", 32'(busy_o), 32'd0);
      check_outputs("R10 collision");
      @(negedge clk);
      chk("R10 still idle", 32'(busy_o), 32'd0);
      check_outputs("R10 after collision");

      // random mix, including back-to-back issue
      for (int i = 0; i < 600; i++) begin
         logic [2:0] rop;
         int sel;
         sel = int'($urandom_range(0, 4));
         rop = (sel < 3) ? 3'(sel) : ((sel == 3) ? 3'b100 : 3'b101);
         run_op(rop, $urandom, $urandom, 5'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule